// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading a two-level page table held in memory. On an accepted request it splits the address into an outer index, an inner index and a byte offset. It checks the outer index against the table length. It then reads the outer entry, and after that the leaf entry, over a word-wide request/response memory port. Each read waits for its response before the walk goes on.

The walk ends in one of two ways. It presents the physical address and the page's protection code for exactly one cycle. Or it presents a fault code for one cycle, so that a trap can be raised and no bad frame is returned. A processor's memory stage or a hardware refill path would issue one request and then wait while `busy` is high.

Top module: `pgw_walker`

## Requirements
- R1: The logical address is split into an outer index in bits 31:22, an inner index in bits 21:10 and a page offset in bits 9:0. The first memory read goes to `table_base + 4*outer_index`.
- R2: The second read starts only after the first response. Its address is `{outer_entry[31:10], 10'b0} + 4*inner_index`.
- R3: If the outer index is greater than or equal to `table_len`, the walk faults with code 1 and makes no memory read. A length of 0 faults every request.
- R4: Bit 0 of every entry is its valid bit. An outer entry with bit 0 clear faults with code 2 after one read. A leaf entry with bit 0 clear faults with code 3 after two reads, and this check comes before the permission check. Permission bits of the outer entry are ignored.
- R5: Leaf bits 2:1 hold the protection code: 0 read-only, 1 read-write, 2 execute-only, 3 no access. Access types are 0 read, 1 write, 2 execute and 3 reserved. Read is allowed on codes 0 and 1, write only on code 1, execute only on code 2. A reserved access is never allowed. A disallowed access faults with code 4.
- R6: On success the physical address is `{leaf[31:10], offset}` and `done_perm` equals leaf bits 2:1.
- R7: `busy` rises at the edge that accepts a request and stays high through the single cycle in which `done_valid` or `fault_valid` is high. The cycle after that, all three are low.
- R8: `req_valid` is ignored while `busy` is high. It neither changes the walk in progress nor starts another walk.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_rsp_valid` arrives, whatever the response latency.
- R10: After reset, `busy`, `mem_req_valid`, `done_valid` and `fault_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_vaddr | input | 32 | Logical address |
| req_access | input | 2 | Access type (0 read, 1 write, 2 execute) |
| table_base | input | 32 | Byte address of the outer table, sampled at accept |
| table_len | input | 11 | Number of outer entries, sampled at accept |
| busy | output | 1 | Walk in progress, including the result cycle |
| mem_req_valid | output | 1 | Word read request, held until response |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle pulse with a successful translation |
| done_paddr | output | 32 | Physical address |
| done_perm | output | 2 | Protection code of the leaf entry |
| fault_valid | output | 1 | One-cycle pulse with a fault |
| fault_code | output | 3 | 1 length, 2 outer invalid, 3 leaf invalid, 4 permission |

## Verification
Walks run against a small sparse memory model. The bench logs the address of every read, so it can tell an error in the outer index scaling from an error in the inner base concatenation. The leaf entries cover all four protection codes and are tried with every access type, which separates a permission decoder that swaps codes from one that ignores the access type. Outer indices just below, at and beyond the table length, including a length of zero, test the bound comparison. A walk with a three-cycle response delay and a request pulse sent in the middle of a walk test the hold of the read port and the guard that ignores requests while busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OUTER = 3'd1,
    ST_INNER = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_t;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_LENGTH    = 3'd1,
    FLT_OUTER_INV = 3'd2,
    FLT_INNER_INV = 3'd3,
    FLT_PERM      = 3'd4
  } fault_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] PERM_RO = 2'd0;
  localparam logic [1:0] PERM_RW = 2'd1;
  localparam logic [1:0] PERM_XO = 2'd2;

  function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
    logic ok;
    unique case (acc)
      ACC_READ:  ok = (perm == PERM_RO) || (perm == PERM_RW);
      ACC_WRITE: ok = (perm == PERM_RW);
      ACC_EXEC:  ok = (perm == PERM_XO);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pgw_pte_check.sv
module pgw_pte_check
  import pgw_pkg::*;
(
  input  logic [2:0] pte_lo,
  input  logic [1:0] access,
  input  logic       leaf,
  output fault_t     verdict
);

  always_comb begin
    if (!pte_lo[0]) begin
      verdict = leaf ? FLT_INNER_INV : FLT_OUTER_INV;
    end else if (leaf && !perm_allows(pte_lo[2:1], access)) begin
      verdict = FLT_PERM;
    end else begin
      verdict = FLT_NONE;
    end
  end

endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        len_ok,
  input  logic        rsp_valid,
  input  fault_t      verdict,
  output walk_state_t state
);

  walk_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req_valid) state_nx = len_ok ? ST_OUTER : ST_FAULT;
      ST_OUTER: if (rsp_valid) state_nx = (verdict == FLT_NONE) ? ST_INNER : ST_FAULT;
      ST_INNER: if (rsp_valid) state_nx = (verdict == FLT_NONE) ? ST_DONE : ST_FAULT;
      ST_DONE:  state_nx = ST_IDLE;
      ST_FAULT: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  AST_RESULT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE || state == ST_FAULT) |=> (state == ST_IDLE)); // R7

  AST_WAIT_FOR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUTER && !rsp_valid) |=> (state == ST_OUTER)); // R9

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P1_W  = 10,
  parameter int PTE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  walk_state_t         state,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [1:0]          req_access,
  input  logic [PTE_W-1:0]    table_base,
  input  logic [P1_W:0]       table_len,
  input  logic                rsp_valid,
  input  logic [PTE_W-1:0]    rsp_data,
  input  fault_t              verdict,
  output logic                len_ok,
  output logic [1:0]          access_q,
  output logic [PTE_W-1:0]    rd_addr,
  output logic [PTE_W-1:0]    paddr,
  output logic [1:0]          perm,
  output fault_t              fault
);

  localparam int P2_W  = VA_W - OFF_W - P1_W;
  localparam int LOW_W = P2_W + OFF_W;
  localparam int FRM_W = PTE_W - OFF_W;

  logic [P1_W-1:0]  p1_in;
  logic [LOW_W-1:0] low_q;
  logic [P2_W-1:0]  p2_q;
  logic             accept, outer_hit, inner_hit;

  assign p1_in     = req_vaddr[VA_W-1 -: P1_W];
  assign p2_q      = low_q[OFF_W +: P2_W];
  assign len_ok    = {1'b0, p1_in} < table_len;
  assign accept    = (state == ST_IDLE) && req_valid;
  assign outer_hit = (state == ST_OUTER) && rsp_valid;
  assign inner_hit = (state == ST_INNER) && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= '0;
      access_q <= '0;
    end else if (accept) begin
      low_q    <= req_vaddr[LOW_W-1:0];
      access_q <= req_access;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
    end else if (accept) begin
      rd_addr <= table_base + {{(PTE_W-P1_W-2){1'b0}}, p1_in, 2'b00};
    end else if (outer_hit) begin
      rd_addr <= {rsp_data[PTE_W-1:OFF_W], {OFF_W{1'b0}}}
               + {{(PTE_W-P2_W-2){1'b0}}, p2_q, 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault <= FLT_NONE;
    end else if (accept) begin
      fault <= len_ok ? FLT_NONE : FLT_LENGTH;
    end else if (outer_hit || inner_hit) begin
      fault <= verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr <= '0;
      perm  <= '0;
    end else if (inner_hit) begin
      paddr <= {rsp_data[PTE_W-1 -: FRM_W], low_q[OFF_W-1:0]};
      perm  <= rsp_data[2:1];
    end
  end

  AST_LEN_FAULT_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req_valid && !len_ok) |=> (state == ST_FAULT && fault == FLT_LENGTH)); // R3

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P1_W  = 10,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic [PTE_W-1:0] table_base,
  input  logic [P1_W:0]    table_len,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PTE_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done_valid,
  output logic [PTE_W-1:0] done_paddr,
  output logic [1:0]       done_perm,
  output logic             fault_valid,
  output logic [2:0]       fault_code
);

  walk_state_t state;
  fault_t      verdict;
  fault_t      fault_q;
  logic        len_ok;
  logic [1:0]  access_q;
  logic        unused_pte_bits;

  assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:3];

  pgw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .len_ok    (len_ok),
    .rsp_valid (mem_rsp_valid),
    .verdict   (verdict),
    .state     (state)
  );

  pgw_pte_check u_check (
    .pte_lo  (mem_rsp_data[2:0]),
    .access  (access_q),
    .leaf    (state == ST_INNER),
    .verdict (verdict)
  );

  pgw_datapath #(
    .VA_W (VA_W), .OFF_W (OFF_W), .P1_W (P1_W), .PTE_W (PTE_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_access (req_access),
    .table_base (table_base),
    .table_len  (table_len),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .verdict    (verdict),
    .len_ok     (len_ok),
    .access_q   (access_q),
    .rd_addr    (mem_req_addr),
    .paddr      (done_paddr),
    .perm       (done_perm),
    .fault      (fault_q)
  );

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_OUTER) || (state == ST_INNER);
  assign done_valid    = (state == ST_DONE);
  assign fault_valid   = (state == ST_FAULT);
  assign fault_code    = fault_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_valid, fault_valid})); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && !busy); // R7

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy); // R7

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_FAULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_code != 3'd0)); // R4

endmodule

// File: tb/tb_pgw_walker.sv
module tb_pgw_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_access;
  logic [31:0] table_base;
  logic [10:0] table_len;
  logic        busy, mem_req_valid, done_valid, fault_valid;
  logic [31:0] mem_req_addr, done_paddr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic [1:0]  done_perm;
  logic [2:0]  fault_code;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int lat_cnt;
  int rd_count;
  logic [31:0] rd_last, rd_prev;

  logic [31:0] m_addr [16];
  logic [31:0] m_data [16];
  int m_n = 0;

  always #2 clk = ~clk;

  pgw_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_access(req_access), .table_base(table_base), .table_len(table_len),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_paddr(done_paddr), .done_perm(done_perm),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < 16; i++)
      if (i < m_n && m_addr[i] == a) return m_data[i];
    return 32'h0;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    m_addr[m_n] = a;
    m_data[m_n] = d;
    m_n++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      lat_cnt       <= 0;
      rd_count      <= 0;
      rd_last       <= '0;
      rd_prev       <= '0;
    end else if (mem_rsp_valid) begin
      mem_rsp_valid <= 1'b0;
      lat_cnt       <= 0;
    end else if (mem_req_valid) begin
      if (lat_cnt == lat) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= lookup(mem_req_addr);
        rd_prev       <= rd_last;
        rd_last       <= mem_req_addr;
        rd_count      <= rd_count + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_va(input int p1, input int p2, input int off);
    return (32'(p1) << 22) | (32'(p2) << 10) | 32'(off);
  endfunction

  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam logic [31:0] INNER = 32'h0004_0000;
  localparam logic [31:0] INNR2 = 32'h0008_0000;

  // one walk; exp_fault 0 means success expected
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input int exp_fault,
                      input logic [31:0] exp_pa, input logic [1:0] exp_perm,
                      input int exp_reads, input logic [31:0] a0, input logic [31:0] a1,
                      input string req);
    int start = rd_count;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_access = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
    while (!(done_valid || fault_valid) && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (exp_fault == 0) begin
      chk(done_valid && !fault_valid, req, {fault_valid, 28'd0, fault_code}, 32'd0);
      chk(done_paddr == exp_pa, {req, " paddr R6"}, done_paddr, exp_pa);
      chk(done_perm == exp_perm, {req, " perm R6"}, 32'(done_perm), 32'(exp_perm));
    end else begin
      chk(fault_valid && !done_valid && fault_code == 3'(exp_fault), req,
          {fault_valid, 28'd0, fault_code}, {1'b1, 28'd0, 3'(exp_fault)});
    end
    @(negedge clk);
    chk(!busy && !done_valid && !fault_valid, "R7 one-cycle result then idle",
        {29'd0, busy, done_valid, fault_valid}, 32'd0);
    chk(rd_count - start == exp_reads, {req, " read count"}, 32'(rd_count - start), 32'(exp_reads));
    if (exp_reads == 2) begin
      chk(rd_prev == a0, "R1 outer read address", rd_prev, a0);
      chk(rd_last == a1, "R2 inner read address", rd_last, a1);
    end else if (exp_reads == 1) begin
      chk(rd_last == a0, "R1 outer read address", rd_last, a0);
    end
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req_valid && !done_valid && !fault_valid, "R10 reset state",
        {28'd0, busy, mem_req_valid, done_valid, fault_valid}, 32'd0);
  endtask

  task automatic t_success;
    walk(mk_va(3, 5, 'h2A7), 2'd0, 0, 32'h0ABC_D6A7, 2'd1, 2, BASE + 12, INNER + 20, "R1 R2 R6 RW read");
    walk(mk_va(3, 5, 'h001), 2'd1, 0, 32'h0ABC_D401, 2'd1, 2, BASE + 12, INNER + 20, "R5 RW write");
    walk(mk_va(7, 4095, 'h3FF), 2'd2, 0, 32'h1234_5FFF, 2'd2, 2, BASE + 28, INNR2 + 16380, "R1 max index exec");
  endtask

  task automatic t_perm;
    walk(mk_va(3, 6, 'h10), 2'd0, 0, 32'h0000_5010, 2'd0, 2, BASE + 12, INNER + 24, "R5 RO read");
    walk(mk_va(3, 6, 'h10), 2'd1, 4, 0, 0, 2, BASE + 12, INNER + 24, "R5 RO write");
    walk(mk_va(3, 6, 'h10), 2'd2, 4, 0, 0, 2, BASE + 12, INNER + 24, "R5 RO exec");
    walk(mk_va(3, 7, 'h20), 2'd2, 0, 32'h0000_9020, 2'd2, 2, BASE + 12, INNER + 28, "R5 XO exec");
    walk(mk_va(3, 7, 'h20), 2'd0, 4, 0, 0, 2, BASE + 12, INNER + 28, "R5 XO read");
    walk(mk_va(3, 8, 'h0), 2'd0, 4, 0, 0, 2, BASE + 12, INNER + 32, "R5 no-access read");
    walk(mk_va(3, 5, 'h0), 2'd3, 4, 0, 0, 2, BASE + 12, INNER + 20, "R5 reserved access");
  endtask

  task automatic t_valid;
    walk(mk_va(3, 9, 'h0), 2'd0, 3, 0, 0, 2, BASE + 12, INNER + 36, "R4 leaf invalid");
    walk(mk_va(4, 0, 'h0), 2'd0, 2, 0, 0, 1, BASE + 16, 0, "R4 outer invalid");
  endtask

  task automatic t_length;
    walk(mk_va(8, 0, 'h0), 2'd0, 1, 0, 0, 0, 0, 0, "R3 index equals length");
    walk(mk_va(1023, 0, 'h0), 2'd0, 1, 0, 0, 0, 0, 0, "R3 max index");
    table_len = 11'd0;
    walk(mk_va(0, 0, 'h0), 2'd0, 1, 0, 0, 0, 0, 0, "R3 zero length");
    table_len = 11'd8;
  endtask

  task automatic t_latency;
    lat = 3;
    walk(mk_va(3, 5, 'h155), 2'd0, 0, 32'h0ABC_D555, 2'd1, 2, BASE + 12, INNER + 20, "R9 slow memory");
    lat = 0;
  endtask

  task automatic t_busy_ignore;
    int start = rd_count;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = mk_va(3, 5, 'h0AA); req_access = 2'd0;
    @(negedge clk);
    req_vaddr = mk_va(3, 6, 'h011); req_access = 2'd1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done_valid || fault_valid) && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(done_valid && done_paddr == 32'h0ABC_D4AA, "R8 walk unchanged by busy request",
        done_paddr, 32'h0ABC_D4AA);
    @(negedge clk);
    @(negedge clk);
    chk(!busy && rd_count - start == 2, "R8 no second walk started",
        32'(rd_count - start), 32'd2);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_access = '0;
    table_base = BASE; table_len = 11'd8;
    put(BASE + 12, INNER | 32'h7);          // outer p1=3, perm bits ignored
    put(BASE + 28, INNR2 | 32'h1);          // outer p1=7
    put(INNER + 20, 32'h0ABC_D400 | 32'h3); // RW
    put(INNER + 24, 32'h0000_5000 | 32'h1); // RO
    put(INNER + 28, 32'h0000_9000 | 32'h5); // XO
    put(INNER + 32, 32'h0000_A000 | 32'h7); // no access
    put(INNER + 36, 32'h0000_B000 | 32'h2); // invalid leaf
    put(INNR2 + 16380, 32'h1234_5C00 | 32'h5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success();
    t_perm();
    t_valid();
    t_length();
    t_latency();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule